// File: doc/BRIEF.md
# Power-Mode Gate and Clock Controller

This block manages the clock gates of up to twenty functional units and the 8-bit clock-select fields of a shared clock word. Software or a power manager sends one request at a time: either "turn unit N on/off" or "replace the 8-bit field at bit offset P of the clock word". Each unit carries a use counter, so several clients can share a unit. The gate stays open while any client holds it.

A change is never made to the configuration the chip is running from. The controller keeps two banks, each holding a gate word and a clock word. It writes the new pair into the bank that is not in use, then moves the 2-bit power mode over to that bank. A settle window follows, and new requests are ignored until it expires. Another agent, such as a sleep sequencer, can load the power mode directly, which is how the alternate mode 2 and the illegal mode 3 can be entered.

Top module: `pm_gate_ctrl`

## Requirements
- R1: After reset, both banks' gate and clock words, all use counts and the power mode are zero, and busy and err are low.
- R2: An accepted enable request (req_kind=0, unit_on=1) adds one to the unit's count. When the count leaves zero, the unit's gate bit goes to 1, a flip takes place, and the gate word in the target bank has that bit set.
- R3: An accepted disable request (req_kind=0, unit_on=0) takes one from the count. The gate bit clears only when the count reaches zero; a count that is still nonzero causes no flip.
- R4: A disable request for a unit whose count is zero raises err for exactly one cycle, and no bank, count or mode changes.
- R5: If the requested gate value already equals the unit's current gate bit, neither bank is written, the mode is unchanged and busy stays low.
- R6: A flip in mode 1 writes the current gate and clock words into bank 0 and sets mode 0. A flip in mode 0 or mode 2 writes them into bank 1 and sets mode 1. The other bank is untouched.
- R7: While the mode is 3, every request raises err and changes nothing.
- R8: After a flip, busy is high for exactly SETTLE_CYC cycles. A request presented while busy is ignored: no err and no change.
- R9: A clock request (req_kind=1) replaces bits [fld_pos+7:fld_pos] of the current clock word with fld_val. Field bits above the top of the word are dropped and the other bits are kept. The request always flips.
- R10: A unit index of N_UNITS or more raises err and changes nothing.
- R11: An enable request for a unit whose count is at its maximum (2^CNT_W-1) raises err and changes nothing.
- R12: mode_ld loads mode_ld_val into the power mode on the next edge. It takes priority over a request in the same cycle, and that request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_kind | input | 1 | 0 = unit gate request, 1 = clock field write |
| unit_idx | input | IDX_W | Unit number for a gate request |
| unit_on | input | 1 | 1 = enable (take a use), 0 = disable (drop a use) |
| fld_pos | input | POS_W | Bit offset of the clock field |
| fld_val | input | FIELD_W | New clock field value |
| mode_ld | input | 1 | Load the power mode directly |
| mode_ld_val | input | 2 | Value for mode_ld |
| bank0_gate | output | N_UNITS | Bank 0 gate word |
| bank0_clk | output | CLK_W | Bank 0 clock word |
| bank1_gate | output | N_UNITS | Bank 1 gate word |
| bank1_clk | output | CLK_W | Bank 1 clock word |
| cur_mode | output | 2 | Active power mode |
| busy | output | 1 | Settle window in progress |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
Directed sequences cover several unit paths. One unit's use count is driven 0→1→2→1→0, which tells a flip on a gate edge apart from a plain count step that must not flip, and then goes one step below zero. A second unit is pushed to count saturation to separate the overflow rejection from a normal enable. Clock writes at low and high offsets show that the field is merged, not overwritten, and that bits above the word are dropped. Mode loads of 2 and 3, and a load in the same cycle as a request, tell the ping-pong target rule apart from the illegal-mode and priority rules. A random request stream, including out-of-range units and requests made during the settle window, is then checked against the behavioural model on every cycle.

// File: rtl/pmg_pkg.sv
package pmg_pkg;
  localparam logic [1:0] MODE_B0  = 2'd0;  // bank 0 active
  localparam logic [1:0] MODE_B1  = 2'd1;  // bank 1 active
  localparam logic [1:0] MODE_ALT = 2'd2;  // alternate, flips like mode 0
  localparam logic [1:0] MODE_BAD = 2'd3;  // illegal

  typedef enum logic {
    REQ_UNIT = 1'b0,
    REQ_CLK  = 1'b1
  } req_kind_e;
endpackage

// File: rtl/pmg_use_cnt.sv
module pmg_use_cnt #(
  parameter int N_UNITS = 20,
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_cnt
);
  localparam logic [IDX_W:0] NU = N_UNITS[IDX_W:0];

  logic [CNT_W-1:0] cnt_q [N_UNITS];

  for (genvar g = 0; g < N_UNITS; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) cnt_q[g] <= wr_cnt;
    end
  end

  always_comb begin
    rd_cnt = '0;
    if ({1'b0, rd_idx} < NU) rd_cnt = cnt_q[rd_idx];
  end
endmodule

// File: rtl/pmg_settle.sv
module pmg_settle #(
  parameter int SETTLE_CYC = 4000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (start)         left_q <= SW'(SETTLE_CYC);
    else if (left_q != '0)  left_q <= left_q - SW'(1);
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/pmg_bank_pair.sv
module pmg_bank_pair #(
  parameter int N_UNITS = 20,
  parameter int CLK_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [N_UNITS-1:0] wr_gate,
  input  logic [CLK_W-1:0]   wr_clk,
  output logic [N_UNITS-1:0] gate0,
  output logic [CLK_W-1:0]   clk0,
  output logic [N_UNITS-1:0] gate1,
  output logic [CLK_W-1:0]   clk1
);
  logic [N_UNITS-1:0] gate_q [2];
  logic [CLK_W-1:0]   clkw_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        gate_q[b] <= '0;
        clkw_q[b] <= '0;
      end else if (wr_en && wr_sel == 1'(b)) begin
        gate_q[b] <= wr_gate;
        clkw_q[b] <= wr_clk;
      end
    end
  end

  assign gate0 = gate_q[0];
  assign clk0  = clkw_q[0];
  assign gate1 = gate_q[1];
  assign clk1  = clkw_q[1];
endmodule

// File: rtl/pm_gate_ctrl.sv
module pm_gate_ctrl
  import pmg_pkg::*;
#(
  parameter int N_UNITS    = 20,
  parameter int CNT_W      = 8,
  parameter int CLK_W      = 32,
  parameter int FIELD_W    = 8,
  parameter int SETTLE_CYC = 4000000,
  parameter int IDX_W      = $clog2(N_UNITS),
  parameter int POS_W      = $clog2(CLK_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_kind,
  input  logic [IDX_W-1:0]   unit_idx,
  input  logic               unit_on,
  input  logic [POS_W-1:0]   fld_pos,
  input  logic [FIELD_W-1:0] fld_val,
  input  logic               mode_ld,
  input  logic [1:0]         mode_ld_val,
  output logic [N_UNITS-1:0] bank0_gate,
  output logic [CLK_W-1:0]   bank0_clk,
  output logic [N_UNITS-1:0] bank1_gate,
  output logic [CLK_W-1:0]   bank1_clk,
  output logic [1:0]         cur_mode,
  output logic               busy,
  output logic               err
);
  localparam logic [IDX_W:0]   NU      = N_UNITS[IDX_W:0];
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CLK_W-1:0] FMASK   = {{(CLK_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

  logic [1:0]         mode_q;
  logic [N_UNITS-1:0] live_gate_q;
  logic [CLK_W-1:0]   live_clk_q;
  logic               err_q;

  logic               accept, idx_ok, reject, flip, cnt_we;
  logic [IDX_W-1:0]   idx_s;
  logic [CNT_W-1:0]   cnt_cur, cnt_nxt;
  logic               want;
  logic [N_UNITS-1:0] gate_nxt;
  logic [CLK_W-1:0]   clk_nxt;
  logic               tgt_sel;
  req_kind_e          kind;

  pmg_use_cnt #(.N_UNITS(N_UNITS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst(rst),
    .rd_idx(unit_idx), .rd_cnt(cnt_cur),
    .wr_en(cnt_we), .wr_idx(unit_idx), .wr_cnt(cnt_nxt)
  );

  pmg_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .start(flip), .busy(busy)
  );

  pmg_bank_pair #(.N_UNITS(N_UNITS), .CLK_W(CLK_W)) u_banks (
    .clk(clk), .rst(rst),
    .wr_en(flip), .wr_sel(tgt_sel), .wr_gate(gate_nxt), .wr_clk(clk_nxt),
    .gate0(bank0_gate), .clk0(bank0_clk), .gate1(bank1_gate), .clk1(bank1_clk)
  );

  // Request decode: one request is resolved in the cycle it is accepted.
  always_comb begin
    kind     = req_kind_e'(req_kind);
    accept   = req_valid && !busy && !mode_ld;
    idx_ok   = ({1'b0, unit_idx} < NU);
    idx_s    = idx_ok ? unit_idx : '0;
    cnt_nxt  = unit_on ? cnt_cur + CNT_W'(1) : cnt_cur - CNT_W'(1);
    want     = (cnt_nxt != '0);
    gate_nxt = live_gate_q;
    clk_nxt  = live_clk_q;
    reject   = (mode_q == MODE_BAD);
    if (kind == REQ_UNIT) begin
      if (!idx_ok) reject = 1'b1;
      if (!unit_on && cnt_cur == '0) reject = 1'b1;
      if (unit_on && cnt_cur == CNT_MAX) reject = 1'b1;
      gate_nxt[idx_s] = want;
    end else begin
      clk_nxt = (live_clk_q & ~(FMASK << fld_pos)) |
                ({{(CLK_W-FIELD_W){1'b0}}, fld_val} << fld_pos);
    end
    cnt_we  = accept && !reject && (kind == REQ_UNIT);
    flip    = accept && !reject &&
              ((kind == REQ_CLK) || (live_gate_q[idx_s] != want));
    tgt_sel = (mode_q == MODE_B1) ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_B0;
      live_gate_q <= '0;
      live_clk_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= accept && reject;
      if (mode_ld) begin
        mode_q <= mode_ld_val;
      end else if (flip) begin
        mode_q      <= tgt_sel ? MODE_B1 : MODE_B0;
        live_gate_q <= gate_nxt;
        live_clk_q  <= clk_nxt;
      end
    end
  end

  assign cur_mode = mode_q;
  assign err      = err_q;
endmodule

// File: rtl/pmg_checker.sv
module pmg_checker #(
  parameter int N_UNITS = 20,
  parameter int CLK_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               mode_ld,
  input logic               busy,
  input logic               err,
  input logic [1:0]         cur_mode,
  input logic [N_UNITS-1:0] bank0_gate,
  input logic [N_UNITS-1:0] bank1_gate,
  input logic [CLK_W-1:0]   bank0_clk,
  input logic [CLK_W-1:0]   bank1_clk
);
  // A mode change not caused by a direct load starts the settle window.
  p_flip_busy_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!mode_ld) && cur_mode != $past(cur_mode)) |-> busy);

  // Nothing moves while settling, except a direct mode load.
  p_hold_busy_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(mode_ld)) |->
      ($stable(cur_mode) && $stable(bank0_gate) && $stable(bank1_gate)
       && $stable(bank0_clk) && $stable(bank1_clk)));

  // A rejected request leaves the banks and the mode alone.
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (err && !$past(mode_ld)) |->
      ($stable(cur_mode) && $stable(bank0_gate) && $stable(bank1_gate)));

  // Rejections never start a settle window.
  p_err_no_busy_r4: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);

  // Only one bank is written per flip, and it matches the new mode.
  p_one_bank_r6: assert property (@(posedge clk) disable iff (rst)
    !((!$stable(bank0_gate) || !$stable(bank0_clk)) &&
      (!$stable(bank1_gate) || !$stable(bank1_clk))));

  p_bank1_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bank1_gate) || !$stable(bank1_clk)) |-> cur_mode == 2'd1);

  p_bank0_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bank0_gate) || !$stable(bank0_clk)) |-> cur_mode == 2'd0);
endmodule

bind pm_gate_ctrl pmg_checker #(.N_UNITS(N_UNITS), .CLK_W(CLK_W)) u_chk (
  .clk(clk), .rst(rst), .mode_ld(mode_ld), .busy(busy), .err(err),
  .cur_mode(cur_mode), .bank0_gate(bank0_gate), .bank1_gate(bank1_gate),
  .bank0_clk(bank0_clk), .bank1_clk(bank1_clk)
);

// File: tb/sim_pm_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pm_gate_ctrl;
  localparam int NU = 20, CW = 2, KW = 32, FW = 8, ST = 6;
  localparam int IW = 5, PW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_kind = 0, unit_on = 0, mode_ld = 0;
  logic [IW-1:0] unit_idx = '0;
  logic [PW-1:0] fld_pos = '0;
  logic [FW-1:0] fld_val = '0;
  logic [1:0] mode_ld_val = '0;
  logic [NU-1:0] bank0_gate, bank1_gate;
  logic [KW-1:0] bank0_clk, bank1_clk;
  logic [1:0] cur_mode;
  logic busy, err;

  always #2 clk = ~clk;

  pm_gate_ctrl #(.N_UNITS(NU), .CNT_W(CW), .CLK_W(KW), .FIELD_W(FW),
                 .SETTLE_CYC(ST)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .unit_idx(unit_idx), .unit_on(unit_on), .fld_pos(fld_pos),
    .fld_val(fld_val), .mode_ld(mode_ld), .mode_ld_val(mode_ld_val),
    .bank0_gate(bank0_gate), .bank0_clk(bank0_clk),
    .bank1_gate(bank1_gate), .bank1_clk(bank1_clk),
    .cur_mode(cur_mode), .busy(busy), .err(err));

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";

  // Behavioural reference model
  int m_cnt[NU];
  bit [NU-1:0] m_gate, m_b0g, m_b1g;
  bit [KW-1:0] m_clk, m_b0c, m_b1c;
  int m_mode, m_left;
  bit m_err;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_gate = 0; m_b0g = 0; m_b1g = 0; m_clk = 0; m_b0c = 0; m_b1c = 0;
      m_mode = 0; m_left = 0; m_err = 0;
    end else begin
      bit idle, bad, doflip;
      bit [NU-1:0] ng;
      bit [KW-1:0] nc;
      int nct;
      idle = (m_left == 0);
      if (m_left > 0) m_left--;
      m_err = 0;
      if (mode_ld) m_mode = mode_ld_val;
      else if (req_valid && idle) begin
        ng = m_gate; nc = m_clk; nct = 0; doflip = 0;
        bad = (m_mode == 3);
        if (!req_kind) begin
          if (unit_idx >= NU) bad = 1;
          else begin
            if (!unit_on && m_cnt[unit_idx] == 0) bad = 1;
            if (unit_on && m_cnt[unit_idx] == (1 << CW) - 1) bad = 1;
          end
          if (!bad) begin
            nct = m_cnt[unit_idx] + (unit_on ? 1 : -1);
            m_cnt[unit_idx] = nct;
            ng[unit_idx] = (nct != 0);
            doflip = (ng != m_gate);
          end
        end else if (!bad) begin
          nc = (m_clk & ~(32'hFF << fld_pos)) | (32'(fld_val) << fld_pos);
          doflip = 1;
        end
        m_err = bad;
        if (doflip) begin
          m_gate = ng; m_clk = nc;
          if (m_mode == 1) begin m_b0g = ng; m_b0c = nc; m_mode = 0; end
          else begin m_b1g = ng; m_b1c = nc; m_mode = 1; end
          m_left = ST;
        end
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) if (!rst) begin
    n_chk++;
    if (bank0_gate !== m_b0g || bank1_gate !== m_b1g || bank0_clk !== m_b0c ||
        bank1_clk !== m_b1c || cur_mode !== 2'(m_mode) ||
        busy !== (m_left != 0) || err !== m_err) begin
      n_fail++;
      $display("FAIL %s cyc %0d: act g0=%h g1=%h c0=%h c1=%h m=%0d b=%0d e=%0d exp g0=%h g1=%h c0=%h c1=%h m=%0d b=%0d e=%0d",
               phase, cyc, bank0_gate, bank1_gate, bank0_clk, bank1_clk, cur_mode, busy, err,
               m_b0g, m_b1g, m_b0c, m_b1c, m_mode, m_left != 0, m_err);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  // Drive one request (and/or mode load) for one cycle; returns at the negedge after the edge.
  task automatic op(input bit k, input int idx, input bit on, input int pos = 0,
                    input int val = 0, input bit ld = 0, input int ldv = 0);
    req_valid = !(ld && idx < 0); req_kind = k; unit_idx = IW'(idx < 0 ? 0 : idx);
    unit_on = on; fld_pos = PW'(pos); fld_val = FW'(val);
    mode_ld = ld; mode_ld_val = 2'(ldv);
    @(negedge clk);
    req_valid = 0; mode_ld = 0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act running exp done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R1";
    chk("R1", {bank0_gate, bank1_gate}, 0);
    chk("R1", {bank0_clk, bank1_clk}, 0);
    chk("R1", {cur_mode, busy, err}, 0);

    phase = "R2";
    op(0, 3, 1);
    chk("R2", bank1_gate, 64'h8);
    chk("R6", cur_mode, 1);
    begin
      int n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R8", n, ST);
    end

    phase = "R8";
    op(0, 5, 1);                   // mode 1 -> bank 0
    chk("R6", bank0_gate, 64'h28);
    op(0, 7, 1);                   // dropped while settling
    chk("R8", {bank1_gate, err}, {20'h8, 1'b0});
    settle();
    chk("R8", bank0_gate, 64'h28);

    phase = "R5";
    op(0, 3, 1);                   // count 2, bit already set
    chk("R5", {cur_mode, busy}, {2'd0, 1'b0});

    phase = "R3";
    op(0, 3, 0);                   // count 1, no flip
    chk("R3", {cur_mode, busy}, {2'd0, 1'b0});
    op(0, 3, 0);                   // count 0, gate clears
    chk("R3", bank1_gate, 64'h20);
    chk("R6", bank0_gate, 64'h28);
    settle();

    phase = "R4";
    op(0, 3, 0);
    chk("R4", {err, cur_mode}, {1'b1, 2'd1});
    @(negedge clk);
    chk("R4", err, 0);

    phase = "R10";
    op(0, 20, 1); chk("R10", err, 1);
    op(0, 31, 0); chk("R10", err, 1);

    phase = "R9";
    op(1, 0, 0, 8, 8'hA5);
    chk("R9", bank0_clk, 64'h0000A500);
    chk("R6", bank0_gate, 64'h20);
    settle();
    op(1, 0, 0, 28, 8'hFF);
    chk("R9", bank1_clk, 64'hF000A500);
    settle();
    op(1, 0, 0, 8, 8'h3C);
    chk("R9", bank0_clk, 64'hF0003C00);
    settle();

    phase = "R12";
    op(0, -1, 0, 0, 0, 1, 2);
    chk("R12", cur_mode, 2);
    phase = "R6";
    op(0, 5, 0);                   // mode 2 -> bank 1
    chk("R6", {bank1_gate, cur_mode}, {20'h0, 2'd1});
    chk("R6", bank0_gate, 64'h20);
    settle();

    phase = "R7";
    op(0, -1, 0, 0, 0, 1, 3);
    op(0, 6, 1);
    chk("R7", {err, cur_mode}, {1'b1, 2'd3});
    op(1, 0, 0, 0, 8'h11);
    chk("R7", {err, bank0_clk[7:0], bank1_clk[7:0]}, {1'b1, 16'h0});

    phase = "R12";
    op(0, 6, 1, 0, 0, 1, 1);       // load wins, request dropped
    chk("R12", {cur_mode, busy, err}, {2'd1, 1'b0, 1'b0});
    op(0, 6, 1);
    chk("R2", {bank0_gate, cur_mode}, {20'h40, 2'd0});
    settle();

    phase = "R11";
    for (int i = 0; i < 3; i++) begin op(0, 9, 1); settle(); end
    op(0, 9, 1);
    chk("R11", err, 1);
    chk("R11", bank1_gate, 64'h240);
    for (int i = 0; i < 3; i++) begin op(0, 9, 0); settle(); end
    chk("R3", bank0_gate, 64'h40);

    phase = "RAND R2..R12";
    for (int i = 0; i < 500; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0) op(0, -1, 0, 0, 0, 1, $urandom_range(0, 3));
      else op(r < 6, $urandom_range(0, 21), $urandom_range(0, 1),
              $urandom_range(0, 31), $urandom_range(0, 255));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    settle();
    finish_run();
  end
endmodule